// File: doc/BRIEF.md
# Physical Address Command Completion Tracker

This block carries one flash media command from acceptance to completion. A command arrives with an opcode, a zero-based address count and a 64-bit address field. When the count field is zero the address field is the one physical address to access. Otherwise the block pulls one 64-bit address per access from a list-entry stream. It fetches each entry only after the previous access has finished, so the upstream list reader never runs ahead.

Each address goes to a back-end access port through a valid/ready request, and one pass/fail response comes back per request. The block records each result as one bit of a 64-bit completion word and derives an overall status code from the failures and the command type. A single command is handled at a time. A new command is taken only after the completion output has been consumed.

Top module: `ppa_cmd_tracker`

## Requirements
- R1: After reset, `cmdReady` is 1 and `listReady`, `beReqValid` and `cplValid` are 0.
- R2: A count field of 0 issues exactly one back-end request, carrying `cmdAddr`, and never raises `listReady`.
- R3: A count field of N>0 fetches N+1 list entries, one at a time. Entry i+1 is requested only after the response for entry i. Each entry is issued as one request in arrival order.
- R4: Bit i of `cplWord` is 1 exactly when the response for access i reported failure (`beRspFail`=1). Bits above the count field are 0.
- R5: The supported opcodes are 90h erase, 91h write, 92h read, 95h raw write and 96h raw read. `cplCode` is 00h when no access failed. It is 80h when a write or raw-write access failed, and 81h when a read or raw-read access failed.
- R6: Failures of an erase set bits in `cplWord` but leave `cplCode` at 00h.
- R7: For erase, the sector field (bits 1:0) and the page field (bits 10:2) of each issued address are driven as 0. All other opcodes issue the address unchanged. `beReqOp` carries the command opcode.
- R8: Any other opcode completes with `cplCode` 01h and `cplWord` 0, and issues no back-end request.
- R9: `cmdReady` is 0 from command acceptance until the completion is taken. `cplValid`, `cplWord` and `cplCode` hold until `cplReady`, and after the handshake `cmdReady` returns to 1.
- R10: A back-end request holds its address and opcode until `beReqReady`. `beRspValid` has no effect unless a request has been accepted and its response is still due.
- R11: A count field of 63 handles 64 accesses, and each of the 64 word bits reflects its own access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle, command accepted this cycle if valid |
| cmdOpcode | input | 8 | Media opcode |
| cmdCount | input | 6 | Zero-based address count |
| cmdAddr | input | 64 | Direct address (count 0) or list pointer |
| listValid | input | 1 | List entry offered |
| listReady | output | 1 | Block wants the next list entry |
| listAddr | input | 64 | List entry address |
| beReqValid | output | 1 | Back-end access request |
| beReqReady | input | 1 | Back-end takes the request |
| beReqAddr | output | 64 | Address to access |
| beReqOp | output | 8 | Opcode of the access |
| beRspValid | input | 1 | Back-end result present |
| beRspFail | input | 1 | Result is a failure |
| cplValid | output | 1 | Completion present |
| cplReady | input | 1 | Completion consumed |
| cplWord | output | 64 | Per-access failure bits |
| cplCode | output | 8 | Overall status code |

## Verification
The hardest situation to reach is a long list command in which every access has its own failure outcome, combined with stalled requests, delayed responses and stray response pulses while the block is still waiting for a list entry. The stimulus draws opcodes, counts and failure masks from a seeded random generator and inserts random request stalls and response delays. Directed cases pin the count extremes 0 and 63, an all-fail list, an invalid opcode and a spurious response during a list fetch.

// File: rtl/ppa_trk_pkg.sv
package ppa_trk_pkg;
  localparam logic [7:0] OP_ERASE  = 8'h90;
  localparam logic [7:0] OP_WRITE  = 8'h91;
  localparam logic [7:0] OP_READ   = 8'h92;
  localparam logic [7:0] OP_RWRITE = 8'h95;
  localparam logic [7:0] OP_RREAD  = 8'h96;

  localparam logic [7:0] SC_OK     = 8'h00;
  localparam logic [7:0] SC_BADOP  = 8'h01;
  localparam logic [7:0] SC_WFAULT = 8'h80;
  localparam logic [7:0] SC_RDERR  = 8'h81;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT, S_DONE} trkState_e;
  typedef enum logic [1:0] {K_BAD, K_ERASE, K_WRITE, K_READ} opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeCmd;
    logic takeList;
    logic takeRsp;
  } trkStrobe_t;

  function automatic opKind_e decodeOp(input logic [7:0] op);
    case (op)
      OP_ERASE:            return K_ERASE;
      OP_WRITE, OP_RWRITE: return K_WRITE;
      OP_READ, OP_RREAD:   return K_READ;
      default:             return K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/ppa_trk_ctrl.sv
module ppa_trk_ctrl
  import ppa_trk_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdOpcode,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic             listValid,
  input  logic             beReqReady,
  input  logic             beRspValid,
  input  logic             cplReady,
  input  logic             lastIdx,
  output logic             cmdReady,
  output logic             listReady,
  output logic             beReqValid,
  output logic             cplValid,
  output trkStrobe_t       strobe
);
  trkState_e state, nextState;

  always_comb begin
    nextState  = state;
    strobe     = '0;
    cmdReady   = 1'b0;
    listReady  = 1'b0;
    beReqValid = 1'b0;
    cplValid   = 1'b0;
    case (state)
      S_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          strobe.takeCmd = 1'b1;
          if (decodeOp(cmdOpcode) == K_BAD) nextState = S_DONE;
          else if (cmdCount == '0)          nextState = S_ISSUE;
          else                              nextState = S_FETCH;
        end
      end
      S_FETCH: begin
        listReady = 1'b1;
        if (listValid) begin
          strobe.takeList = 1'b1;
          nextState = S_ISSUE;
        end
      end
      S_ISSUE: begin
        beReqValid = 1'b1;
        if (beReqReady) nextState = S_WAIT;
      end
      S_WAIT: begin
        if (beRspValid) begin
          strobe.takeRsp = 1'b1;
          nextState = lastIdx ? S_DONE : S_FETCH;
        end
      end
      S_DONE: begin
        cplValid = 1'b1;
        if (cplReady) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    beReqValid && !beReqReady |=> beReqValid);
  // R9
  cpl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplValid && !cplReady |=> cplValid && !cmdReady);
  // R8
  badop_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady && cmdValid && decodeOp(cmdOpcode) == K_BAD |=> cplValid);
  // R9
  one_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdReady, listReady, beReqValid, cplValid}));
endmodule

// File: rtl/ppa_trk_dpath.sv
module ppa_trk_dpath
  import ppa_trk_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int MAX_PPA  = 64,
  parameter int CNT_W    = 6,
  parameter int SECT_LSB = 0,
  parameter int SECT_W   = 2,
  parameter int PAGE_LSB = 2,
  parameter int PAGE_W   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  trkStrobe_t         strobe,
  input  logic [7:0]         cmdOpcode,
  input  logic [CNT_W-1:0]   cmdCount,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [ADDR_W-1:0]  listAddr,
  input  logic               beRspFail,
  output logic               lastIdx,
  output logic [ADDR_W-1:0]  beReqAddr,
  output logic [7:0]         beReqOp,
  output logic [MAX_PPA-1:0] cplWord,
  output logic [7:0]         cplCode
);
  localparam int SECT_HI = SECT_LSB + SECT_W;
  localparam int PAGE_HI = PAGE_LSB + PAGE_W;

  logic [7:0]         opReg;
  opKind_e            kindReg;
  logic [CNT_W-1:0]   cntReg;
  logic [CNT_W-1:0]   idxReg;
  logic [ADDR_W-1:0]  ppaReg;
  logic [MAX_PPA-1:0] wordReg;
  logic               anyFail;
  logic [ADDR_W-1:0]  keepBits;

  // erase keeps every bit outside the page and sector fields
  for (genvar g = 0; g < ADDR_W; g++) begin : gKeep
    localparam bit IN_SECT = (g >= SECT_LSB) && (g < SECT_HI);
    localparam bit IN_PAGE = (g >= PAGE_LSB) && (g < PAGE_HI);
    assign keepBits[g] = !(IN_SECT || IN_PAGE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= '0;
      kindReg <= K_BAD;
      cntReg  <= '0;
      idxReg  <= '0;
      ppaReg  <= '0;
      wordReg <= '0;
      anyFail <= 1'b0;
    end else begin
      if (strobe.takeCmd) begin
        opReg   <= cmdOpcode;
        kindReg <= decodeOp(cmdOpcode);
        cntReg  <= cmdCount;
        idxReg  <= '0;
        ppaReg  <= cmdAddr;
        wordReg <= '0;
        anyFail <= 1'b0;
      end
      if (strobe.takeList) ppaReg <= listAddr;
      if (strobe.takeRsp) begin
        if (beRspFail) begin
          wordReg[idxReg] <= 1'b1;
          anyFail         <= 1'b1;
        end
        if (!lastIdx) idxReg <= idxReg + 1'b1;
      end
    end
  end

  assign lastIdx   = (idxReg == cntReg);
  assign beReqAddr = (kindReg == K_ERASE) ? (ppaReg & keepBits) : ppaReg;
  assign beReqOp   = opReg;
  assign cplWord   = wordReg;

  always_comb begin
    if (kindReg == K_BAD)         cplCode = SC_BADOP;
    else if (!anyFail)            cplCode = SC_OK;
    else if (kindReg == K_WRITE)  cplCode = SC_WFAULT;
    else if (kindReg == K_READ)   cplCode = SC_RDERR;
    else                          cplCode = SC_OK;
  end

  // R4
  word_high_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((wordReg >> cntReg) >> 1) == '0);
  // R4
  fail_bit_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeRsp && beRspFail |=> wordReg[$past(idxReg)]);
  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeRsp && !lastIdx |=> idxReg == $past(idxReg) + 1'b1);
endmodule

// File: rtl/ppa_cmd_tracker.sv
module ppa_cmd_tracker
  import ppa_trk_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int MAX_PPA  = 64,
  parameter int SECT_LSB = 0,
  parameter int SECT_W   = 2,
  parameter int PAGE_LSB = 2,
  parameter int PAGE_W   = 9,
  localparam int CNT_W   = $clog2(MAX_PPA)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [7:0]         cmdOpcode,
  input  logic [CNT_W-1:0]   cmdCount,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic               listValid,
  output logic               listReady,
  input  logic [ADDR_W-1:0]  listAddr,
  output logic               beReqValid,
  input  logic               beReqReady,
  output logic [ADDR_W-1:0]  beReqAddr,
  output logic [7:0]         beReqOp,
  input  logic               beRspValid,
  input  logic               beRspFail,
  output logic               cplValid,
  input  logic               cplReady,
  output logic [MAX_PPA-1:0] cplWord,
  output logic [7:0]         cplCode
);
  trkStrobe_t strobe;
  logic       lastIdx;

  ppa_trk_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .cmdCount(cmdCount), .listValid(listValid), .beReqReady(beReqReady),
    .beRspValid(beRspValid), .cplReady(cplReady), .lastIdx(lastIdx),
    .cmdReady(cmdReady), .listReady(listReady), .beReqValid(beReqValid),
    .cplValid(cplValid), .strobe(strobe)
  );

  ppa_trk_dpath #(
    .ADDR_W(ADDR_W), .MAX_PPA(MAX_PPA), .CNT_W(CNT_W),
    .SECT_LSB(SECT_LSB), .SECT_W(SECT_W), .PAGE_LSB(PAGE_LSB), .PAGE_W(PAGE_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdOpcode(cmdOpcode),
    .cmdCount(cmdCount), .cmdAddr(cmdAddr), .listAddr(listAddr),
    .beRspFail(beRspFail), .lastIdx(lastIdx), .beReqAddr(beReqAddr),
    .beReqOp(beReqOp), .cplWord(cplWord), .cplCode(cplCode)
  );

  // R10
  req_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    beReqValid && !beReqReady |=> $stable(beReqAddr) && $stable(beReqOp));
  // R9
  cpl_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplValid && !cplReady |=> $stable(cplWord) && $stable(cplCode));
endmodule

// File: tb/ppa_cmd_tracker_tb.sv
module ppa_cmd_tracker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdReady;
  logic [7:0]  cmdOpcode = '0;
  logic [5:0]  cmdCount = '0;
  logic [63:0] cmdAddr = '0;
  logic        listValid = 1'b0, listReady;
  logic [63:0] listAddr = '0;
  logic        beReqValid, beReqReady = 1'b0;
  logic [63:0] beReqAddr;
  logic [7:0]  beReqOp;
  logic        beRspValid = 1'b0, beRspFail = 1'b0;
  logic        cplValid, cplReady = 1'b0;
  logic [63:0] cplWord;
  logic [7:0]  cplCode;

  int errCnt = 0;
  int chkCnt = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  ppa_cmd_tracker u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOpcode(cmdOpcode), .cmdCount(cmdCount), .cmdAddr(cmdAddr),
    .listValid(listValid), .listReady(listReady), .listAddr(listAddr),
    .beReqValid(beReqValid), .beReqReady(beReqReady), .beReqAddr(beReqAddr),
    .beReqOp(beReqOp), .beRspValid(beRspValid), .beRspFail(beRspFail),
    .cplValid(cplValid), .cplReady(cplReady), .cplWord(cplWord), .cplCode(cplCode)
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isValidOp(input logic [7:0] op);
    return op == 8'h90 || op == 8'h91 || op == 8'h92 || op == 8'h95 || op == 8'h96;
  endfunction

  function automatic logic [7:0] expCode(input logic [7:0] op, input bit anyFail);
    if (!isValidOp(op)) return 8'h01;
    if (!anyFail) return 8'h00;
    if (op == 8'h91 || op == 8'h95) return 8'h80;
    if (op == 8'h92 || op == 8'h96) return 8'h81;
    return 8'h00;
  endfunction

  function automatic logic [63:0] expAddr(input logic [7:0] op, input logic [63:0] a);
    return (op == 8'h90) ? (a & ~64'h7FF) : a;
  endfunction

  function automatic logic [63:0] cntMask(input int cnt);
    return (cnt == 63) ? '1 : ((64'd1 << (cnt + 1)) - 64'd1);
  endfunction

  task automatic runCmd(input logic [7:0] op, input int cnt, input logic [63:0] failM, input bit spur);
    logic [63:0] addrs [64];
    logic [63:0] expW;
    logic [63:0] ea;
    string       tag;
    for (int i = 0; i < 64; i++) addrs[i] = {$urandom(), $urandom()};
    @(negedge clk);
    chk(cmdReady, "R9 idle ready", 64'(cmdReady), 64'd1);
    cmdValid  = 1'b1;
    cmdOpcode = op;
    cmdCount  = 6'(cnt);
    cmdAddr   = (cnt == 0) ? addrs[0] : {$urandom(), $urandom()};
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(!cmdReady, "R9 busy", 64'(cmdReady), 64'd0);
    if (isValidOp(op)) begin
      for (int i = 0; i <= cnt; i++) begin
        if (cnt != 0) begin
          chk(listReady && !beReqValid, "R3 fetch before issue", {listReady, beReqValid}, 64'd2);
          if (spur && i == 0) begin
            beRspValid = 1'b1;
            beRspFail  = 1'b1;
          end
          listValid = 1'b1;
          listAddr  = addrs[i];
          @(posedge clk);
          @(negedge clk);
          listValid  = 1'b0;
          beRspValid = 1'b0;
          beRspFail  = 1'b0;
        end else begin
          chk(!listReady, "R2 no list fetch", 64'(listReady), 64'd0);
        end
        ea  = expAddr(op, addrs[i]);
        tag = (op == 8'h90) ? "R7 erase addr" : ((cnt == 0) ? "R2 direct addr" : "R3 list addr");
        chk(beReqValid && beReqAddr == ea, tag, beReqAddr, ea);
        chk(beReqOp == op, "R7 opcode", 64'(beReqOp), 64'(op));
        for (int s = 0; s < int'($urandom_range(0, 2)); s++) begin
          @(negedge clk);
          chk(beReqValid && beReqAddr == ea, "R10 request hold", beReqAddr, ea);
        end
        beReqReady = 1'b1;
        @(posedge clk);
        @(negedge clk);
        beReqReady = 1'b0;
        for (int d = 0; d < int'($urandom_range(0, 2)); d++) begin
          @(negedge clk);
          chk(!beReqValid && !listReady, "R3 waits response", {beReqValid, listReady}, 64'd0);
        end
        beRspValid = 1'b1;
        beRspFail  = failM[i];
        @(posedge clk);
        @(negedge clk);
        beRspValid = 1'b0;
        beRspFail  = 1'b0;
      end
    end else begin
      chk(!beReqValid && !listReady, "R8 no request", {beReqValid, listReady}, 64'd0);
    end
    expW = isValidOp(op) ? (failM & cntMask(cnt)) : 64'd0;
    chk(cplValid, "R9 completion shown", 64'(cplValid), 64'd1);
    tag = (!isValidOp(op)) ? "R8 word" : ((cnt == 63) ? "R11 word" : ((op == 8'h90) ? "R6 word" : "R4 word"));
    chk(cplWord == expW, tag, cplWord, expW);
    tag = (!isValidOp(op)) ? "R8 code" : ((op == 8'h90) ? "R6 code" : "R5 code");
    chk(cplCode == expCode(op, expW != 0), tag, 64'(cplCode), 64'(expCode(op, expW != 0)));
    @(negedge clk);
    chk(cplValid && !cmdReady && cplWord == expW, "R9 completion hold", cplWord, expW);
    cplReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cplReady = 1'b0;
    chk(!cplValid && cmdReady, "R9 release", {cplValid, cmdReady}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] ops [6];
    ops[0] = 8'h90; ops[1] = 8'h91; ops[2] = 8'h92;
    ops[3] = 8'h95; ops[4] = 8'h96; ops[5] = 8'h93;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(cmdReady && !listReady && !beReqValid && !cplValid, "R1 reset state",
        {cmdReady, listReady, beReqValid, cplValid}, 64'h8);
    // directed corners
    runCmd(8'h91, 0, 64'd1, 1'b0);                   // R2, R5 write fault
    runCmd(8'h92, 0, 64'd0, 1'b0);                   // R2 read pass
    runCmd(8'h96, 63, '1, 1'b0);                     // R11 all fail
    runCmd(8'h95, 63, 64'h8000_0000_0000_0001, 1'b0);// R11 edge bits
    runCmd(8'h90, 5, 64'h2D, 1'b0);                  // R6, R7
    runCmd(8'h92, 3, 64'h4, 1'b1);                   // R10 stray response
    runCmd(8'h00, 7, '1, 1'b0);                      // R8
    runCmd(8'hFF, 0, '1, 1'b0);                      // R8
    for (int n = 0; n < 40; n++) begin
      logic [7:0]  op;
      int          cnt;
      logic [63:0] fm;
      op  = ops[$urandom_range(0, 5)];
      cnt = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 63));
      fm  = ($urandom_range(0, 2) == 0) ? 64'd0 : {$urandom(), $urandom()};
      runCmd(op, cnt, fm & ~64'd1, cnt != 0 && $urandom_range(0, 3) == 0);
    end
    report();
  end
endmodule